// File: doc/BRIEF.md
# TDM Serial Port with DMA Word Counters

This block is a time-division-multiplexed audio serial port. A frame holds eight slots of 32 bits each. A bit clock and a frame pulse arrive from outside. Inside, the block keeps a small transmit buffer and a small receive buffer, and each side runs a descending word counter in the manner of a DMA channel. All logic runs on the core clock. The bit clock, frame pulse and serial input pass through a two-stage synchroniser, and the block acts on the detected edges of the bit clock.

The transmit side primes a two-word queue from buffer addresses 0 and 1 before slot 0 begins. As a result its counter starts two words below the receive counter, and it reaches zero at the end of slot 5. The receive counter reaches zero only after the last bit of slot 7 has been sampled. Each zero crossing produces a one-cycle interrupt pulse, and the transmit pulse comes two slots before the receive pulse. The transmit queue reloads from addresses 0 and 1 as soon as slot 7's word has entered the shifter. Because of this, the slot 0 and slot 1 words of the next frame are fixed at that point. A frame pulse that arrives while a frame is in progress restarts both sides and sets a sticky error flag.

Top module: `tdm_dma_seq`

## Requirements
- R1: A frame pulse seen high at a falling bit-clock edge opens a frame. The next rising edge drives bit 0 of slot 0. Each slot then goes out MSB first, with the output changing only after rising edges, over 8 slots of 32 bits. Outside a frame `sd_out` is 0.
- R2: Once the frame pulse has been taken and before slot 0 starts, `tx_count` reads 6 and `rx_count` reads 8.
- R3: `tx_count` drops by one at the end of each of slots 0 to 5. `rx_count` drops by one each time the last bit of a slot is sampled on a falling edge. Sampled in the middle of slots 0..7, the counts are 6,5,4,3,2,1,0,6 (transmit) and 8,7,6,5,4,3,2,1 (receive).
- R4: `tx_irq` is high for exactly one core cycle per frame. It rises in the cycle after `tx_count` becomes 0 at the end of slot 5.
- R5: `rx_irq` is high for exactly one core cycle per frame. It rises in the cycle after `rx_count` becomes 0 at the sampling of slot 7's last bit. It follows `tx_irq` by 63.5 bit-clock periods.
- R6: The word received in slot k is stored at receive buffer address k and can be read combinationally through `rx_rd_addr`/`rx_rd_data`. After slot 7, `rx_count` stays 0 until the next frame pulse.
- R7: When slot 7's word enters the shifter, the transmit queue reloads from buffer addresses 0 and 1 and `tx_count` returns to 6. Words written to addresses 0 and 1 after that point appear one frame later. Words written to addresses 2..7 before they are fetched appear in the next frame.
- R8: A frame pulse taken while a frame is active sets `sync_err`, which stays set until reset. It also restarts framing at slot 0, re-primes the transmit queue from addresses 0 and 1 (`tx_count` 6) and reloads `rx_count` to 8.
- R9: After reset, `tx_irq`, `rx_irq`, `sync_err` and `sd_out` are 0, `tx_count` is 0 and `rx_count` is 8. The first frame pulse primes the transmit queue.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | Serial bit clock, asynchronous to `clk` |
| fsync | input | 1 | Frame pulse, one bit period wide |
| sd_in | input | 1 | Serial receive data |
| sd_out | output | 1 | Serial transmit data |
| tx_wr_en | input | 1 | Transmit buffer write enable |
| tx_wr_addr | input | AW (3) | Transmit buffer write address |
| tx_wr_data | input | 32 | Transmit buffer write data |
| rx_rd_addr | input | AW (3) | Receive buffer read address |
| rx_rd_data | output | 32 | Receive buffer read data |
| tx_count | output | CW (4) | Transmit word counter |
| rx_count | output | CW (4) | Receive word counter |
| tx_irq | output | 1 | Transmit zero-count pulse |
| rx_irq | output | 1 | Receive zero-count pulse |
| sync_err | output | 1 | Sticky mid-frame frame-pulse flag |

## Verification
The bench builds the block with its default eight slots of 32 bits. It loops `sd_out` back to `sd_in` and runs a bit clock of 16 core cycles. With these values the transmit-to-receive interrupt gap is an exact count of 1016 core cycles. A full frame also fits in about four thousand cycles, so the bench can run three frames: a primed first frame, a second frame whose buffer was rewritten after the reload point (this exposes the two-word prefetch latency), and a frame cut short by a mid-frame pulse.

// File: rtl/tdm_pkg.sv
package tdm_pkg;

  // Words held in the transmit queue ahead of the shifter at slot 0.
  localparam int PREFETCH = 2;

  // Frame events passed from the framing logic to the transmit side.
  typedef struct packed {
    logic load;    // frame pulse taken
    logic force_ld; // frame pulse taken while a frame was active
    logic move;    // queue head enters the shifter
    logic shift;   // advance one bit
    logic stop;    // frame finished, clear shifter
  } tx_ev_t;

endpackage

// File: rtl/tdm_edge_sync.sv
module tdm_edge_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic sclk,
  input  logic fsync,
  input  logic sd_in,
  output logic rise_p,
  output logic fall_p,
  output logic fs_s,
  output logic sd_s
);

  logic [2:0] s1_q, s2_q;
  logic       sclk_d_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q     <= '0;
      s2_q     <= '0;
      sclk_d_q <= 1'b0;
    end else begin
      s1_q     <= {sd_in, fsync, sclk};
      s2_q     <= s1_q;
      sclk_d_q <= s2_q[0];
    end
  end

  assign rise_p = s2_q[0] & ~sclk_d_q;
  assign fall_p = ~s2_q[0] & sclk_d_q;
  assign fs_s   = s2_q[1];
  assign sd_s   = s2_q[2];

endmodule

// File: rtl/tdm_tx_path.sv
module tdm_tx_path import tdm_pkg::*; #(
  parameter int SLOTS = 8,
  parameter int W     = 32,
  parameter int AW    = 3,
  parameter int CW    = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [W-1:0]  wr_data,
  input  tx_ev_t        ev,
  output logic          sd_out,
  output logic [CW-1:0] count,
  output logic          irq
);

  logic [W-1:0]  mem_q [SLOTS];
  logic [W-1:0]  sh_q, sh_d, q0_q, q0_d, q1_q, q1_d;
  logic          q1v_q, q1v_d, prim_q, prim_d, irq_q, irq_d, reload;
  logic [AW-1:0] ptr_q, ptr_d;
  logic [CW-1:0] cnt_q, cnt_d;

  always_ff @(posedge clk) begin
    if (wr_en) mem_q[wr_addr] <= wr_data;
  end

  always_comb begin
    sh_d   = sh_q;
    q0_d   = q0_q;
    q1_d   = q1_q;
    q1v_d  = q1v_q;
    prim_d = prim_q;
    ptr_d  = ptr_q;
    cnt_d  = cnt_q;
    irq_d  = 1'b0;
    reload = 1'b0;
    if (ev.load && (ev.force_ld || !prim_q)) begin
      reload = 1'b1;
      sh_d   = '0;
    end else if (ev.move) begin
      sh_d = q0_q;
      if (q1v_q) begin
        q0_d  = q1_q;
        q1v_d = 1'b0;
      end else if (cnt_q != '0) begin
        q0_d  = mem_q[ptr_q];
        ptr_d = ptr_q + 1'b1;
        cnt_d = cnt_q - 1'b1;
        irq_d = (cnt_q == CW'(1));
      end else begin
        reload = 1'b1;
      end
    end else if (ev.shift) begin
      sh_d = {sh_q[W-2:0], 1'b0};
    end else if (ev.stop) begin
      sh_d = '0;
    end
    if (reload) begin
      q0_d   = mem_q[0];
      q1_d   = mem_q[1];
      q1v_d  = 1'b1;
      prim_d = 1'b1;
      ptr_d  = AW'(PREFETCH);
      cnt_d  = CW'(SLOTS - PREFETCH);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '0;
      q0_q   <= '0;
      q1_q   <= '0;
      q1v_q  <= 1'b0;
      prim_q <= 1'b0;
      ptr_q  <= '0;
      cnt_q  <= '0;
      irq_q  <= 1'b0;
    end else begin
      sh_q   <= sh_d;
      q0_q   <= q0_d;
      q1_q   <= q1_d;
      q1v_q  <= q1v_d;
      prim_q <= prim_d;
      ptr_q  <= ptr_d;
      cnt_q  <= cnt_d;
      irq_q  <= irq_d;
    end
  end

  assign sd_out = sh_q[W-1];
  assign count  = cnt_q;
  assign irq    = irq_q;

endmodule

// File: rtl/tdm_rx_path.sv
module tdm_rx_path #(
  parameter int SLOTS = 8,
  parameter int W     = 32,
  parameter int AW    = 3,
  parameter int CW    = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reload,
  input  logic          sample,
  input  logic          word_end,
  input  logic          sd,
  input  logic [AW-1:0] rd_addr,
  output logic [W-1:0]  rd_data,
  output logic [CW-1:0] count,
  output logic          irq
);

  logic [W-1:0]  mem_q [SLOTS];
  logic [W-2:0]  rsh_q, rsh_d;
  logic [AW-1:0] wptr_q, wptr_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          irq_d, irq_q, we;

  assign we = sample & word_end & (cnt_q != '0) & ~reload;

  always_ff @(posedge clk) begin
    if (we) mem_q[wptr_q] <= {rsh_q, sd};
  end

  always_comb begin
    rsh_d  = rsh_q;
    wptr_d = wptr_q;
    cnt_d  = cnt_q;
    irq_d  = 1'b0;
    if (reload) begin
      rsh_d  = '0;
      wptr_d = '0;
      cnt_d  = CW'(SLOTS);
    end else if (sample) begin
      rsh_d = {rsh_q[W-3:0], sd};
      if (we) begin
        wptr_d = wptr_q + 1'b1;
        cnt_d  = cnt_q - 1'b1;
        irq_d  = (cnt_q == CW'(1));
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsh_q  <= '0;
      wptr_q <= '0;
      cnt_q  <= CW'(SLOTS);
      irq_q  <= 1'b0;
    end else begin
      rsh_q  <= rsh_d;
      wptr_q <= wptr_d;
      cnt_q  <= cnt_d;
      irq_q  <= irq_d;
    end
  end

  assign rd_data = mem_q[rd_addr];
  assign count   = cnt_q;
  assign irq     = irq_q;

endmodule

// File: rtl/tdm_dma_seq.sv
module tdm_dma_seq import tdm_pkg::*; #(
  parameter int  SLOTS     = 8,
  parameter int  SLOT_BITS = 32,
  localparam int AW        = $clog2(SLOTS),
  localparam int CW        = $clog2(SLOTS + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 sclk,
  input  logic                 fsync,
  input  logic                 sd_in,
  output logic                 sd_out,
  input  logic                 tx_wr_en,
  input  logic [AW-1:0]        tx_wr_addr,
  input  logic [SLOT_BITS-1:0] tx_wr_data,
  input  logic [AW-1:0]        rx_rd_addr,
  output logic [SLOT_BITS-1:0] rx_rd_data,
  output logic [CW-1:0]        tx_count,
  output logic [CW-1:0]        rx_count,
  output logic                 tx_irq,
  output logic                 rx_irq,
  output logic                 sync_err
);

  localparam int BW = $clog2(SLOT_BITS);
  localparam int PW = $clog2(SLOTS * SLOT_BITS);
  localparam logic [PW-1:0] LAST = PW'(SLOTS * SLOT_BITS - 1);

  logic [1:0] rst_q;
  logic       rst_sn;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_q <= '0;
    else        rst_q <= {rst_q[0], 1'b1};
  end
  assign rst_sn = rst_q[1];

  logic rise_p, fall_p, fs_s, sd_s;

  tdm_edge_sync u_sync (
    .clk(clk), .rst_n(rst_sn), .sclk(sclk), .fsync(fsync), .sd_in(sd_in),
    .rise_p(rise_p), .fall_p(fall_p), .fs_s(fs_s), .sd_s(sd_s)
  );

  logic          active_q, active_d, armed_q, armed_d, err_q, err_d;
  logic [PW-1:0] pos_q, pos_d;
  logic          fs_evt, start, slot_end, last;
  tx_ev_t        tx_ev;

  assign fs_evt   = fall_p & fs_s;
  assign start    = rise_p & armed_q;
  assign slot_end = &pos_q[BW-1:0];
  assign last     = (pos_q == LAST);

  always_comb begin
    active_d = active_q;
    armed_d  = armed_q;
    err_d    = err_q;
    pos_d    = pos_q;
    if (fs_evt) begin
      armed_d  = 1'b1;
      active_d = 1'b0;
      if (active_q) err_d = 1'b1;
    end else if (start) begin
      armed_d  = 1'b0;
      active_d = 1'b1;
      pos_d    = '0;
    end else if (rise_p && active_q) begin
      if (last) active_d = 1'b0;
      else      pos_d    = pos_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      active_q <= 1'b0;
      armed_q  <= 1'b0;
      err_q    <= 1'b0;
      pos_q    <= '0;
    end else begin
      active_q <= active_d;
      armed_q  <= armed_d;
      err_q    <= err_d;
      pos_q    <= pos_d;
    end
  end

  assign tx_ev.load     = fs_evt;
  assign tx_ev.force_ld = active_q;
  assign tx_ev.move     = start | (rise_p & active_q & slot_end & ~last);
  assign tx_ev.shift    = rise_p & active_q & ~slot_end;
  assign tx_ev.stop     = rise_p & active_q & last;

  tdm_tx_path #(.SLOTS(SLOTS), .W(SLOT_BITS), .AW(AW), .CW(CW)) u_tx (
    .clk(clk), .rst_n(rst_sn), .wr_en(tx_wr_en), .wr_addr(tx_wr_addr),
    .wr_data(tx_wr_data), .ev(tx_ev), .sd_out(sd_out), .count(tx_count),
    .irq(tx_irq)
  );

  tdm_rx_path #(.SLOTS(SLOTS), .W(SLOT_BITS), .AW(AW), .CW(CW)) u_rx (
    .clk(clk), .rst_n(rst_sn), .reload(fs_evt),
    .sample(fall_p & active_q & ~fs_s), .word_end(slot_end), .sd(sd_s),
    .rd_addr(rx_rd_addr), .rd_data(rx_rd_data), .count(rx_count),
    .irq(rx_irq)
  );

  assign sync_err = err_q;

endmodule

// File: rtl/tdm_dma_seq_chk.sv
module tdm_dma_seq_chk #(
  parameter int SLOTS = 8,
  parameter int CW    = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          tx_irq,
  input logic          rx_irq,
  input logic [CW-1:0] tx_count,
  input logic [CW-1:0] rx_count,
  input logic          sync_err
);

  a_r4_tx_single: assert property (@(posedge clk) disable iff (!rst_n)
    tx_irq |=> !tx_irq);

  a_r5_rx_single: assert property (@(posedge clk) disable iff (!rst_n)
    rx_irq |=> !rx_irq);

  a_r4_tx_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
    tx_irq |-> (tx_count == '0));

  a_r6_rx_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
    rx_irq |-> (rx_count == '0));

  a_r8_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    sync_err |=> sync_err);

  a_r3_tx_step: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_count != $past(tx_count)) |->
      ((tx_count == $past(tx_count) - 1'b1) || (tx_count == CW'(SLOTS - 2))));

  a_r3_rx_step: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_count != $past(rx_count)) |->
      ((rx_count == $past(rx_count) - 1'b1) || (rx_count == CW'(SLOTS))));

  a_r3_bounds: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_count <= CW'(SLOTS - 2)) && (rx_count <= CW'(SLOTS)));

endmodule

bind tdm_dma_seq tdm_dma_seq_chk #(.SLOTS(SLOTS), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .tx_irq(tx_irq), .rx_irq(rx_irq),
  .tx_count(tx_count), .rx_count(rx_count), .sync_err(sync_err)
);

// File: tb/tb_tdm_dma_seq.sv
module tb_tdm_dma_seq;

  localparam int CLK_PERIOD = 10;
  localparam int HB         = 8;     // core cycles per bit-clock half period
  localparam int GAP        = 1016;  // 63.5 bit periods of 16 cycles

  // Vector table: words 0..7 for the first load, 8..15 for the rewrite.
  localparam logic [31:0] WORDS [16] = '{
    32'hA5C3_0001, 32'h8000_0001, 32'h1234_5678, 32'hFFFF_0000,
    32'h0F0F_F0F0, 32'hDEAD_BEEF, 32'h7FFF_FFFE, 32'hC001_D00D,
    32'h5A5A_5A5A, 32'h0000_0003, 32'hCAFE_F00D, 32'h1357_9BDF,
    32'h8421_8421, 32'hF00D_CAFE, 32'h0246_8ACE, 32'hFEDC_BA98
  };
  localparam int TXC_MID [8] = '{6, 5, 4, 3, 2, 1, 0, 6};
  localparam int RXC_MID [8] = '{8, 7, 6, 5, 4, 3, 2, 1};

  logic        clk, rst_n, sclk, fsync, sd_out;
  logic        tx_wr_en;
  logic [2:0]  tx_wr_addr, rx_rd_addr;
  logic [31:0] tx_wr_data, rx_rd_data;
  logic [3:0]  tx_count, rx_count;
  logic        tx_irq, rx_irq, sync_err;

  tdm_dma_seq dut (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .fsync(fsync), .sd_in(sd_out),
    .sd_out(sd_out), .tx_wr_en(tx_wr_en), .tx_wr_addr(tx_wr_addr),
    .tx_wr_data(tx_wr_data), .rx_rd_addr(rx_rd_addr), .rx_rd_data(rx_rd_data),
    .tx_count(tx_count), .rx_count(rx_count), .tx_irq(tx_irq),
    .rx_irq(rx_irq), .sync_err(sync_err)
  );

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int tx_n = 0, rx_n = 0, tx_t = 0, rx_t = 0;
  logic obit;
  logic [31:0] cap [8];
  logic [31:0] exp_w [8];

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  always @(negedge clk) begin
    cyc <= cyc + 1;
    if (tx_irq) begin tx_n <= tx_n + 1; tx_t <= cyc; end
    if (rx_irq) begin rx_n <= rx_n + 1; rx_t <= cyc; end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bitclk(input logic f);
    @(negedge clk);
    sclk  = 1'b1;
    fsync = f;
    repeat (HB) @(negedge clk);
    sclk = 1'b0;
    repeat (HB - 1) @(negedge clk);
    obit = sd_out;
  endtask

  task automatic write_tx(input int a, input logic [31:0] d);
    @(negedge clk);
    tx_wr_en = 1'b1; tx_wr_addr = 3'(a); tx_wr_data = d;
    @(negedge clk);
    tx_wr_en = 1'b0;
  endtask

  // Run bits [from, 256) of a frame, capturing sd_out and checking counts.
  task automatic run_frame(input int from, input string tag);
    for (int b = from; b < 256; b++) begin
      bitclk(1'b0);
      cap[b / 32] = {cap[b / 32][30:0], obit};
      if (b % 32 == 15) begin
        chk({tag, " R3/R7 tx_count mid slot"}, 32'(tx_count), 32'(TXC_MID[b / 32]));
        chk({tag, " R3 rx_count mid slot"}, 32'(rx_count), 32'(RXC_MID[b / 32]));
      end
    end
    bitclk(1'b0);
    bitclk(1'b0);
  endtask

  task automatic check_frame(input string tag);
    for (int k = 0; k < 8; k++) begin
      chk({tag, " R1 serial word"}, cap[k], exp_w[k]);
      rx_rd_addr = 3'(k);
      #1;
      chk({tag, " R6 rx buffer word"}, rx_rd_data, exp_w[k]);
    end
    chk({tag, " R6 rx_count after slot 7"}, 32'(rx_count), 32'd0);
    chk({tag, " R4 one tx_irq"}, 32'(tx_n), 32'd1);
    chk({tag, " R5 one rx_irq"}, 32'(rx_n), 32'd1);
    chk({tag, " R5 irq gap"}, 32'(rx_t - tx_t), 32'(GAP));
    chk({tag, " R1 idle output"}, 32'(sd_out), 32'd0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; sclk = 1'b0; fsync = 1'b0;
    tx_wr_en = 1'b0; tx_wr_addr = '0; tx_wr_data = '0; rx_rd_addr = '0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R9 reset state
    chk("R9 tx_irq", 32'(tx_irq), 32'd0);
    chk("R9 rx_irq", 32'(rx_irq), 32'd0);
    chk("R9 sync_err", 32'(sync_err), 32'd0);
    chk("R9 sd_out", 32'(sd_out), 32'd0);
    chk("R9 tx_count", 32'(tx_count), 32'd0);
    chk("R9 rx_count", 32'(rx_count), 32'd8);

    // Frame 1: buffer loaded before the first frame pulse.
    for (int k = 0; k < 8; k++) write_tx(k, WORDS[k]);
    bitclk(1'b0);
    chk("R1 idle before frame", 32'(obit), 32'd0);
    bitclk(1'b1);
    chk("R2 tx_count primed", 32'(tx_count), 32'd6);
    chk("R2 rx_count primed", 32'(rx_count), 32'd8);
    tx_n = 0; rx_n = 0;
    run_frame(0, "f1");
    for (int k = 0; k < 8; k++) exp_w[k] = WORDS[k];
    check_frame("f1");

    // Frame 2: rewrite all words after the reload point.
    for (int k = 0; k < 8; k++) write_tx(k, WORDS[8 + k]);
    bitclk(1'b1);
    chk("R7 tx_count kept", 32'(tx_count), 32'd6);
    chk("R2 rx_count reloaded", 32'(rx_count), 32'd8);
    tx_n = 0; rx_n = 0;
    run_frame(0, "f2");
    for (int k = 0; k < 8; k++) exp_w[k] = (k < 2) ? WORDS[k] : WORDS[8 + k];
    check_frame("f2 R7");
    chk("R8 no error on clean frames", 32'(sync_err), 32'd0);

    // Frame 3: mid-frame pulse forces a restart.
    bitclk(1'b1);
    for (int b = 0; b < 100; b++) bitclk(1'b0);
    bitclk(1'b1);
    chk("R8 sync_err set", 32'(sync_err), 32'd1);
    chk("R8 tx_count re-primed", 32'(tx_count), 32'd6);
    chk("R8 rx_count reloaded", 32'(rx_count), 32'd8);
    tx_n = 0; rx_n = 0;
    run_frame(0, "f3");
    for (int k = 0; k < 8; k++) exp_w[k] = WORDS[8 + k];
    check_frame("f3 R8");
    chk("R8 sync_err sticky", 32'(sync_err), 32'd1);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule